// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. It takes an accumulator word, a general-register word, the current carry flag and a 5-bit operation code. The operation code equals bits [7:3] of the 8-bit instruction, so the controller can route those bits straight in without translating them. The block returns a result word, a next-carry value and a zero indication. The controller decides whether to latch the carry and zero values into its flag registers.

The arithmetic group covers add and subtract, each with and without the carry flag, plus increment and decrement. The logical group covers AND, XOR, complement and two pass-through moves. Two rotates move a bit through the carry flag, one to the left and one to the right. A single carry flag serves as the extra input to the carrying arithmetic, as the borrow input to the borrowing arithmetic, and as the ninth bit of both rotates.

Top module: `acc_alu`

## Requirements
- R1: Code 00011 gives result = register operand, and carry out = carry in.
- R2: Code 00100 gives result = (acc + reg) mod 256, and carry out = 1 exactly when acc + reg > 255.
- R3: Code 00101 gives result = (acc - reg) mod 256, and carry out (borrow) = 1 exactly when acc < reg.
- R4: Code 00110 gives (acc + reg + carry in) mod 256, with carry out = 1 when that sum exceeds 255. Code 00111 gives (acc - reg - carry in) mod 256, with carry out = 1 when acc < reg + carry in.
- R5: Code 01000 gives acc AND reg. Code 01001 gives acc XOR reg. For both codes, carry out = carry in.
- R6: Code 01010 rotates right through carry. Result bit 7 = carry in, result bits 6..0 = acc bits 7..1, and carry out = acc bit 0.
- R7: Code 01011 rotates left through carry. Result bit 0 = carry in, result bits 7..1 = acc bits 6..0, and carry out = acc bit 7.
- R8: Code 11010 gives (acc + 1) mod 256, with carry out = 1 when acc = 255. Code 11001 gives (acc - 1) mod 256, with carry out = 1 when acc = 0. Code 11011 gives NOT acc, with carry out = carry in.
- R9: Code 00010 gives result = accumulator operand, and carry out = carry in.
- R10: The zero output is 1 exactly when the 8-bit result is all zeros, for every code.
- R11: Every code not listed above gives result 0 and carry out = carry in. The zero output is therefore 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand |
| gpr_i | input | 8 | General-register operand |
| op_i | input | 5 | Operation code (instruction bits [7:3]) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result word |
| carry_o | output | 1 | Next carry flag value |
| zero_o | output | 1 | Next zero flag value |

## Verification
Some relations hold for every input and are checked whenever the inputs change:
- Subtracting the operands back out of an adder result returns the accumulator.
- A rotate keeps the number of ones across the word and the carry.
- XOR and complement results undo against their operands.
- An AND result has no bit that is absent from either operand.

These checks cannot show that the decoder picked the correct unit for a given code. They also cannot show that untouched codes pass the carry through or clear the result. The bench's per-code scenarios cover those points, together with the wrap and borrow boundaries at 0 and 255.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ACC_OUT = 5'b00010,
        OP_REG_IN  = 5'b00011,
        OP_ADD     = 5'b00100,
        OP_SUB     = 5'b00101,
        OP_ADDC    = 5'b00110,
        OP_SUBC    = 5'b00111,
        OP_AND     = 5'b01000,
        OP_XOR     = 5'b01001,
        OP_ROR_C   = 5'b01010,
        OP_ROL_C   = 5'b01011,
        OP_DEC     = 5'b11001,
        OP_INC     = 5'b11010,
        OP_NOT     = 5'b11011
    } op_e;

    typedef enum logic [1:0] {
        U_NONE,
        U_ARITH,
        U_LOGIC,
        U_ROT
    } unit_e;

    typedef enum logic [2:0] {
        L_ACC,
        L_REG,
        L_AND,
        L_XOR,
        L_NOT
    } lop_e;

    typedef struct packed {
        unit_e unit;
        logic  sub;
        logic  use_c;
        logic  b_one;
        lop_e  lop;
        logic  rot_left;
    } ctrl_t;

    function automatic ctrl_t decode(input logic [OP_W-1:0] code);
        ctrl_t c;
        c = '{unit: U_NONE, sub: 1'b0, use_c: 1'b0, b_one: 1'b0,
              lop: L_ACC, rot_left: 1'b0};
        case (op_e'(code))
            OP_ACC_OUT: begin c.unit = U_LOGIC; c.lop = L_ACC; end
            OP_REG_IN:  begin c.unit = U_LOGIC; c.lop = L_REG; end
            OP_AND:     begin c.unit = U_LOGIC; c.lop = L_AND; end
            OP_XOR:     begin c.unit = U_LOGIC; c.lop = L_XOR; end
            OP_NOT:     begin c.unit = U_LOGIC; c.lop = L_NOT; end
            OP_ADD:     begin c.unit = U_ARITH; end
            OP_SUB:     begin c.unit = U_ARITH; c.sub = 1'b1; end
            OP_ADDC:    begin c.unit = U_ARITH; c.use_c = 1'b1; end
            OP_SUBC:    begin c.unit = U_ARITH; c.sub = 1'b1; c.use_c = 1'b1; end
            OP_INC:     begin c.unit = U_ARITH; c.b_one = 1'b1; end
            OP_DEC:     begin c.unit = U_ARITH; c.sub = 1'b1; c.b_one = 1'b1; end
            OP_ROR_C:   begin c.unit = U_ROT; end
            OP_ROL_C:   begin c.unit = U_ROT; c.rot_left = 1'b1; end
            default:    c.unit = U_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] ext_d;
    logic [W-1:0]  back_d;

    always_comb begin
        if (sub_i)
            ext_d = {1'b0, a_i} - {1'b0, b_i} - XW'(cin_i);
        else
            ext_d = {1'b0, a_i} + {1'b0, b_i} + XW'(cin_i);
    end

    assign sum_o  = ext_d[W-1:0];
    assign cout_o = ext_d[W];

    // Undo the operation on the output word and compare with the accumulator.
    always_comb begin
        if (sub_i)
            back_d = sum_o + b_i + W'(cin_i);
        else
            back_d = sum_o - b_i - W'(cin_i);
        if (!sub_i)
            p_add_inverse_r2: assert (back_d == a_i)
                else $error("adder sum does not invert");
        if (sub_i)
            p_sub_inverse_r3: assert (back_d == a_i)
                else $error("subtractor difference does not invert");
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  lop_e         lop_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        case (lop_i)
            L_ACC:   res_o = a_i;
            L_REG:   res_o = b_i;
            L_AND:   res_o = a_i & b_i;
            L_XOR:   res_o = a_i ^ b_i;
            L_NOT:   res_o = ~a_i;
            default: res_o = '0;
        endcase
    end

    always_comb begin
        if (lop_i == L_XOR)
            p_xor_inverse_r5: assert ((res_o ^ b_i) == a_i)
                else $error("xor result does not invert");
        if (lop_i == L_AND)
            p_and_subset_r5: assert (((res_o & ~a_i) | (res_o & ~b_i)) == '0)
                else $error("and result has a bit outside an operand");
        if (lop_i == L_NOT)
            p_not_inverse_r8: assert ((res_o ^ a_i) == {W{1'b1}})
                else $error("complement is not bitwise opposite");
    end

endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    input  logic         left_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    always_comb begin
        if (left_i) begin
            res_o  = {a_i[W-2:0], cin_i};
            cout_o = a_i[W-1];
        end else begin
            res_o  = {cin_i, a_i[W-1:1]};
            cout_o = a_i[0];
        end
    end

    // A rotate through carry conserves the ones across word and carry.
    always_comb begin
        p_rot_ones_r6: assert (($countones(res_o) + int'(cout_o))
                               == ($countones(a_i) + int'(cin_i)))
            else $error("rotate lost or created a bit");
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    acc_i,
    input  logic [W-1:0]    gpr_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            carry_i,
    output logic [W-1:0]    result_o,
    output logic            carry_o,
    output logic            zero_o
);
    ctrl_t         ctrl_d;
    logic [W-1:0]  add_b_d;
    logic          add_c_d;
    logic [W-1:0]  add_sum_d;
    logic          add_cout_d;
    logic [W-1:0]  log_res_d;
    logic [W-1:0]  rot_res_d;
    logic          rot_cout_d;
    logic [W-1:0]  result_d;
    logic          carry_d;

    always_comb begin
        ctrl_d  = decode(op_i);
        add_b_d = ctrl_d.b_one ? W'(1) : gpr_i;
        add_c_d = ctrl_d.use_c & carry_i;
    end

    acc_alu_adder #(.W(W)) u_adder (
        .a_i    (acc_i),
        .b_i    (add_b_d),
        .cin_i  (add_c_d),
        .sub_i  (ctrl_d.sub),
        .sum_o  (add_sum_d),
        .cout_o (add_cout_d)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .a_i   (acc_i),
        .b_i   (gpr_i),
        .lop_i (ctrl_d.lop),
        .res_o (log_res_d)
    );

    acc_alu_rotate #(.W(W)) u_rotate (
        .a_i    (acc_i),
        .cin_i  (carry_i),
        .left_i (ctrl_d.rot_left),
        .res_o  (rot_res_d),
        .cout_o (rot_cout_d)
    );

    always_comb begin
        case (ctrl_d.unit)
            U_ARITH: begin result_d = add_sum_d; carry_d = add_cout_d; end
            U_LOGIC: begin result_d = log_res_d; carry_d = carry_i;    end
            U_ROT:   begin result_d = rot_res_d; carry_d = rot_cout_d; end
            default: begin result_d = '0;        carry_d = carry_i;    end
        endcase
    end

    assign result_o = result_d;
    assign carry_o  = carry_d;
    assign zero_o   = (result_d == '0);

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc_i = '0;
    logic [7:0] gpr_i = '0;
    logic [4:0] op_i = '0;
    logic       carry_i = 1'b0;
    logic [7:0] result_o;
    logic       carry_o;
    logic       zero_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] r;
        logic       c;
        logic       z;
        string      tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    acc_alu uut (
        .acc_i(acc_i), .gpr_i(gpr_i), .op_i(op_i), .carry_i(carry_i),
        .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o)
    );

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'b00011: return "R1";
            5'b00100: return "R2";
            5'b00101: return "R3";
            5'b00110, 5'b00111: return "R4";
            5'b01000, 5'b01001: return "R5";
            5'b01010: return "R6";
            5'b01011: return "R7";
            5'b11001, 5'b11010, 5'b11011: return "R8";
            5'b00010: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic item_t model(input logic [4:0] op, input int a,
                                    input int b, input int c);
        item_t it;
        int r;
        int co;
        co = c;
        case (op)
            5'b00010: r = a;
            5'b00011: r = b;
            5'b00100: begin r = a + b; co = int'(r > 255); end
            5'b00101: begin r = a - b; co = int'(a < b); end
            5'b00110: begin r = a + b + c; co = int'(r > 255); end
            5'b00111: begin r = a - b - c; co = int'(a < b + c); end
            5'b01000: r = a & b;
            5'b01001: r = a ^ b;
            5'b01010: begin r = (c * 128) + (a / 2); co = a % 2; end
            5'b01011: begin r = (a * 2) + c; co = a / 128; end
            5'b11001: begin r = a - 1; co = int'(a == 0); end
            5'b11010: begin r = a + 1; co = int'(a == 255); end
            5'b11011: r = 255 - a;
            default:  r = 0;
        endcase
        r = r & 255;
        it.r = 8'(r);
        it.c = co[0];
        it.z = (r == 0);
        it.tag = tag_of(op);
        return it;
    endfunction

    task automatic drive(input logic [4:0] op, input int a, input int b,
                         input int c);
        @(negedge clk);
        op_i    = op;
        acc_i   = 8'(a);
        gpr_i   = 8'(b);
        carry_i = c[0];
        sb.push_back(model(op, a, b, c));
    endtask

    // Monitor: compares on the edge after each drive
    initial begin
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                item_t e;
                e = sb.pop_front();
                checks++;
                if (result_o !== e.r || carry_o !== e.c) begin
                    errors++;
                    $display("FAIL %s op=%b a=%h b=%h cin=%b: actual r=%h c=%b expected r=%h c=%b",
                             e.tag, op_i, acc_i, gpr_i, carry_i, result_o, carry_o, e.r, e.c);
                end
                checks++;
                if (zero_o !== e.z) begin
                    errors++;
                    $display("FAIL R10 (%s) op=%b: actual zero=%b expected zero=%b",
                             e.tag, op_i, zero_o, e.z);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: all inputs zero, code 00000 is unlisted (R11)
        drive(5'b00000, 0, 0, 0);
        drive(5'b00011, 8'h11, 8'hA5, 1);              // R1
        drive(5'b00011, 8'h11, 8'h00, 0);              // R1 zero
        drive(5'b00100, 8'h12, 8'h34, 0);              // R2
        drive(5'b00100, 8'hFF, 8'h01, 1);              // R2 wrap, cin ignored
        drive(5'b00100, 8'hF0, 8'h20, 0);              // R2 carry
        drive(5'b00101, 8'h50, 8'h20, 1);              // R3
        drive(5'b00101, 8'h20, 8'h50, 0);              // R3 borrow
        drive(5'b00101, 8'h33, 8'h33, 1);              // R3 equal
        drive(5'b00110, 8'hFE, 8'h01, 1);              // R4 carry chain
        drive(5'b00110, 8'h10, 8'h10, 0);              // R4
        drive(5'b00111, 8'h05, 8'h05, 1);              // R4 borrow by carry
        drive(5'b00111, 8'h05, 8'h04, 1);              // R4 zero
        drive(5'b01000, 8'hF0, 8'h3C, 1);              // R5
        drive(5'b01001, 8'hAA, 8'hAA, 0);              // R5 zero
        drive(5'b01010, 8'h81, 8'h00, 0);              // R6
        drive(5'b01010, 8'h02, 8'h00, 1);              // R6
        drive(5'b01011, 8'h81, 8'h00, 0);              // R7
        drive(5'b01011, 8'h40, 8'h00, 1);              // R7
        drive(5'b11010, 8'hFF, 8'h00, 0);              // R8 inc wrap
        drive(5'b11001, 8'h00, 8'h00, 0);              // R8 dec borrow
        drive(5'b11001, 8'h01, 8'h00, 1);              // R8 dec to zero
        drive(5'b11011, 8'h5A, 8'h00, 1);              // R8 complement
        drive(5'b00010, 8'hC3, 8'h11, 1);              // R9
        drive(5'b00010, 8'h00, 8'h11, 0);              // R9 zero
        // Sweep every code with several operand patterns (R10, R11)
        for (int op = 0; op < 32; op++) begin
            drive(5'(op), 8'h9C, 8'h63, 1);
            drive(5'(op), 8'h01, 8'hFF, 0);
            drive(5'(op), 8'h80, 8'h80, 1);
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule